// File: doc/BRIEF.md
# Thread-Steered Interval Timer

This block is a per-core interval timer. A counter climbs one step per clock. When it meets a programmed limit it wraps to zero and, if the timer is armed, raises one internal pending event. The event is not tied to a single interrupt wire. It fans out to a vector of per-thread interrupt lines, gated by a writable mask that holds one bit per hardware thread. Every thread whose mask bit is set sees the interrupt. Threads whose bit is clear do not.

Software reaches the block through a small register port with a single-cycle write strobe and a combinational read path. There are four registers: count, control, limit and thread mask. To schedule an event, software writes the limit, clears the count, and writes control with both the arm bit and the run-under-debug bit set. Writing control is also the acknowledge: it clears the pending event and loads the new arm state. A debug-halt input freezes counting unless the run-under-debug bit is set. The mask is read-modify-written by each thread, so it reads back exactly as stored.

Top module: `tst_timer`

## Requirements
- R1: After a synchronous reset, all four registers read 0 and every interrupt line is low.
- R2: Register addresses are: count 0x21, control 0x22, limit 0x23, thread mask 0xFFFFF850. The mask occupies bits 15:0 and control occupies bits 1:0. Bit 0 of control is arm and bit 1 is run-under-debug. All other bits, and every unmapped address, read 0.
- R3: `thr_irq` is low on every thread whose mask bit is 0. While an event is pending, `thr_irq` equals the mask.
- R4: While running, the count rises by one per clock. On the clock where count equals limit, the count becomes 0. If arm is set on that clock, the event becomes pending and the interrupt lines are visible after that same edge.
- R5: With arm clear, reaching the limit still wraps the count to 0 but raises no interrupt.
- R6: With run-under-debug clear and `dbg_halt` high, the count holds its value. With run-under-debug set, `dbg_halt` has no effect on counting.
- R7: A control write clears the pending event on its edge and loads bits 1:0. A write of 0b10 acknowledges and leaves the timer disarmed.
- R8: A pending event stays pending, across further count wraps, until control is written.
- R9: A mask write while an event is pending changes the interrupt lines from the next edge onward. A cleared bit deasserts its line.
- R10: A count write on the expiry clock loads the written value and suppresses that expiry. A control write on the expiry clock leaves nothing pending.
- R11: A write to count loads the written value, and counting resumes from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe, one write per asserted clock |
| bus_addr | input | 32 | Register address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| dbg_halt | input | 1 | Debug halt request |
| thr_irq | output | 16 | Per-thread interrupt lines |

## Verification
The assertions assume at most one register write per clock and that `dbg_halt` is a clean synchronous level. They also take the count and control write strobes to be mutually exclusive, because each strobe decodes a single address. The bench drives every input at the falling edge, issues writes one at a time through a task that holds the strobe for exactly one rising edge, and changes `dbg_halt` only between writes. The collision cases of R10 are produced deliberately by timing a single write onto the expiry clock. They are never produced by overlapping strobes.

// File: rtl/tst_pkg.sv
// Package: shared constants and the decoded register selector for the
// thread-steered interval timer. Assumes a 32-bit register port.
package tst_pkg;
    localparam int          DATA_W    = 32;
    localparam int          ADDR_W    = 32;
    localparam logic [31:0] ADDR_CNT  = 32'h0000_0021;
    localparam logic [31:0] ADDR_CTRL = 32'h0000_0022;
    localparam logic [31:0] ADDR_LIM  = 32'h0000_0023;
    localparam logic [31:0] ADDR_MASK = 32'hFFFF_F850;
    localparam int          CTRL_ARM  = 0;
    localparam int          CTRL_RUN  = 1;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CNT,
        SEL_CTRL,
        SEL_LIM,
        SEL_MASK
    } reg_sel_e;
endpackage

// File: rtl/tst_regs.sv
// Register file: decodes the register port, holds control, limit and the
// thread mask, emits write strobes for the count, and muxes read data.
// Assumes at most one write per clock; reads are combinational.
module tst_regs
    import tst_pkg::*;
#(
    parameter int NUM_THREADS = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_we,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [DATA_W-1:0]      bus_wdata,
    input  logic [DATA_W-1:0]      count_val,
    output logic                   ctrl_arm,
    output logic                   ctrl_run,
    output logic [DATA_W-1:0]      limit_val,
    output logic [NUM_THREADS-1:0] mask_val,
    output logic                   cnt_we,
    output logic                   ctrl_we,
    output logic [DATA_W-1:0]      bus_rdata
);
    reg_sel_e sel;
    logic     lim_we;
    logic     mask_we;

    // Address decode to a one-of-four selector.
    always_comb begin
        unique case (bus_addr)
            ADDR_CNT:  sel = SEL_CNT;
            ADDR_CTRL: sel = SEL_CTRL;
            ADDR_LIM:  sel = SEL_LIM;
            ADDR_MASK: sel = SEL_MASK;
            default:   sel = SEL_NONE;
        endcase
    end

    assign cnt_we  = bus_we && (sel == SEL_CNT);
    assign ctrl_we = bus_we && (sel == SEL_CTRL);
    assign lim_we  = bus_we && (sel == SEL_LIM);
    assign mask_we = bus_we && (sel == SEL_MASK);

    // Control bits: arm and run-under-debug.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_arm <= 1'b0;
            ctrl_run <= 1'b0;
        end else if (ctrl_we) begin
            ctrl_arm <= bus_wdata[CTRL_ARM];
            ctrl_run <= bus_wdata[CTRL_RUN];
        end
    end

    // Limit register.
    always_ff @(posedge clk) begin
        if (!rst_n)      limit_val <= '0;
        else if (lim_we) limit_val <= bus_wdata;
    end

    // Thread mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_val <= '0;
        else if (mask_we) mask_val <= bus_wdata[NUM_THREADS-1:0];
    end

    // Read-data mux; unmapped addresses and unused bits read zero.
    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            SEL_CNT:  bus_rdata = count_val;
            SEL_CTRL: begin
                bus_rdata[CTRL_ARM] = ctrl_arm;
                bus_rdata[CTRL_RUN] = ctrl_run;
            end
            SEL_LIM:  bus_rdata = limit_val;
            SEL_MASK: bus_rdata[NUM_THREADS-1:0] = mask_val;
            default:  bus_rdata = '0;
        endcase
    end

    // R7 control write loads both control bits.
    a_r7_ctrl_load: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we |=> (ctrl_arm == $past(bus_wdata[CTRL_ARM])) &&
                    (ctrl_run == $past(bus_wdata[CTRL_RUN])));
    // R2 mask holds without a mask write.
    a_r2_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_we |=> $stable(mask_val));
endmodule

// File: rtl/tst_counter.sv
// Counter and expiry: counts up while running, wraps at the limit and
// sets a pending flag on an armed expiry. Assumes the count and control
// write strobes never coincide. Count writes win over counting and
// suppress the expiry; control writes clear pending with priority.
module tst_counter
    import tst_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_we,
    input  logic [DATA_W-1:0] cnt_wdata,
    input  logic [DATA_W-1:0] limit_val,
    input  logic              ctrl_arm,
    input  logic              ctrl_run,
    input  logic              ctrl_we,
    input  logic              dbg_halt,
    output logic [DATA_W-1:0] count_val,
    output logic              pending
);
    logic running;
    logic hit;

    assign running = ctrl_run || !dbg_halt;
    assign hit     = (count_val == limit_val);

    // Count register: load, else step or wrap while running.
    always_ff @(posedge clk) begin
        if (!rst_n)       count_val <= '0;
        else if (cnt_we)  count_val <= cnt_wdata;
        else if (running) count_val <= hit ? '0 : count_val + 1'b1;
    end

    // Pending event: cleared by control write, set by armed expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)                                    pending <= 1'b0;
        else if (ctrl_we)                              pending <= 1'b0;
        else if (running && hit && ctrl_arm && !cnt_we) pending <= 1'b1;
    end

    // R4 armed expiry raises pending.
    a_r4_expiry_pends: assert property (@(posedge clk) disable iff (!rst_n)
        (running && hit && ctrl_arm && !cnt_we && !ctrl_we) |=> pending);
    // R4 the count wraps to zero at the limit.
    a_r4_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (running && hit && !cnt_we) |=> (count_val == '0));
    // R6 a halted count holds.
    a_r6_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !cnt_we) |=> $stable(count_val));
    // R7 control write acknowledges.
    a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we |=> !pending);
    // R8 pending persists until acknowledged.
    a_r8_pending_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !ctrl_we) |=> pending);
    // R11 count write loads the value.
    a_r11_count_load: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> (count_val == $past(cnt_wdata)));
endmodule

// File: rtl/tst_fanout.sv
// Interrupt fan-out: gates the single pending event onto each thread's
// line through its mask bit. Purely combinational.
module tst_fanout #(
    parameter int NUM_THREADS = 16
) (
    input  logic                   pending,
    input  logic [NUM_THREADS-1:0] mask_val,
    output logic [NUM_THREADS-1:0] thr_irq
);
    // One gate per hardware thread.
    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        assign thr_irq[t] = pending & mask_val[t];
    end
endmodule

// File: rtl/tst_timer.sv
// Top: thread-steered interval timer. Connects the register file, the
// counter and the interrupt fan-out. Assumes one register write per clock.
module tst_timer
    import tst_pkg::*;
#(
    parameter int NUM_THREADS = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_we,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [DATA_W-1:0]      bus_wdata,
    output logic [DATA_W-1:0]      bus_rdata,
    input  logic                   dbg_halt,
    output logic [NUM_THREADS-1:0] thr_irq
);
    logic                   ctrl_arm;
    logic                   ctrl_run;
    logic                   cnt_we;
    logic                   ctrl_we;
    logic                   pending;
    logic [DATA_W-1:0]      limit_val;
    logic [DATA_W-1:0]      count_val;
    logic [NUM_THREADS-1:0] mask_val;

    tst_regs #(.NUM_THREADS(NUM_THREADS)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .count_val(count_val), .ctrl_arm(ctrl_arm),
        .ctrl_run(ctrl_run), .limit_val(limit_val), .mask_val(mask_val),
        .cnt_we(cnt_we), .ctrl_we(ctrl_we), .bus_rdata(bus_rdata)
    );

    tst_counter u_cnt (
        .clk(clk), .rst_n(rst_n), .cnt_we(cnt_we), .cnt_wdata(bus_wdata),
        .limit_val(limit_val), .ctrl_arm(ctrl_arm), .ctrl_run(ctrl_run),
        .ctrl_we(ctrl_we), .dbg_halt(dbg_halt), .count_val(count_val),
        .pending(pending)
    );

    tst_fanout #(.NUM_THREADS(NUM_THREADS)) u_fan (
        .pending(pending), .mask_val(mask_val), .thr_irq(thr_irq)
    );

    // R1 reset leaves all lines low and count zero.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (thr_irq == '0) && (count_val == '0));
    // R3 unselected threads are never interrupted.
    a_r3_mask_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_irq & ~mask_val) == '0);
    // R3 a pending event reaches every selected thread.
    a_r3_fan_full: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> (thr_irq == mask_val));
    // R10 count write on the expiry clock suppresses the event.
    a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_we && !pending) |=> (thr_irq == '0));
endmodule

// File: tb/tst_timer_test.sv
// Directed bench: one task per scenario, each checking its own results.
module tst_timer_test;
    localparam logic [31:0] A_CNT  = 32'h21;
    localparam logic [31:0] A_CTRL = 32'h22;
    localparam logic [31:0] A_LIM  = 32'h23;
    localparam logic [31:0] A_MASK = 32'hFFFF_F850;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        dbg_halt = 1'b0;
    logic [15:0] thr_irq;
    int          n_checks = 0;
    int          n_errors = 0;

    tst_timer uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dbg_halt(dbg_halt),
        .thr_irq(thr_irq)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(input logic [31:0] a, output logic [31:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(A_CNT, v);  check("R1 count", v, 0);
        rd(A_CTRL, v); check("R1 ctrl", v, 0);
        rd(A_LIM, v);  check("R1 limit", v, 0);
        rd(A_MASK, v); check("R1 mask", v, 0);
        check("R1 irq", {16'h0, thr_irq}, 0);
    endtask

    task automatic t_regmap;
        logic [31:0] v;
        wr(A_MASK, 32'hFFFF_00A5);
        rd(A_MASK, v); check("R2 mask readback", v, 32'h0000_00A5);
        wr(A_CTRL, 32'hFFFF_FFF0);
        rd(A_CTRL, v); check("R2 ctrl unused bits", v, 0);
        rd(32'h24, v); check("R2 unmapped", v, 0);
        wr(A_LIM, 5);
        rd(A_LIM, v);  check("R2 limit readback", v, 5);
    endtask

    task automatic t_schedule;
        logic [31:0] v;
        wr(A_CNT, 0);
        wr(A_CTRL, 3);
        rd(A_CNT, v); check("R4 count step", v, 1);
        rd(A_CTRL, v); check("R2 ctrl readback", v, 3);
        idle(4);
        rd(A_CNT, v); check("R4 at limit", v, 5);
        check("R4 no irq before expiry", {16'h0, thr_irq}, 0);
        idle(1);
        rd(A_CNT, v); check("R4 wrap", v, 0);
        check("R3 irq equals mask", {16'h0, thr_irq}, 32'h00A5);
        idle(10);
        check("R8 pending held", {16'h0, thr_irq}, 32'h00A5);
    endtask

    task automatic t_mask_live;
        wr(A_MASK, 32'h0005);
        check("R9 mask narrowed", {16'h0, thr_irq}, 32'h0005);
        wr(A_MASK, 32'h8005);
        check("R9 mask widened", {16'h0, thr_irq}, 32'h8005);
    endtask

    task automatic t_ack;
        logic [31:0] v;
        wr(A_CTRL, 2);
        check("R7 ack clears", {16'h0, thr_irq}, 0);
        rd(A_CTRL, v); check("R7 ctrl loaded", v, 2);
        idle(14);
        check("R7 disarmed stays quiet", {16'h0, thr_irq}, 0);
    endtask

    task automatic t_disarmed_wrap;
        logic [31:0] v;
        wr(A_CNT, 0);
        idle(5);
        rd(A_CNT, v); check("R5 reaches limit", v, 5);
        idle(1);
        rd(A_CNT, v); check("R5 wraps", v, 0);
        check("R5 no irq", {16'h0, thr_irq}, 0);
    endtask

    task automatic t_halt;
        logic [31:0] v;
        wr(A_CTRL, 0);
        wr(A_CNT, 100);
        dbg_halt = 1'b1;
        idle(4);
        rd(A_CNT, v); check("R6 frozen", v, 100);
        wr(A_CTRL, 2);
        rd(A_CNT, v); check("R6 frozen on write edge", v, 100);
        idle(3);
        rd(A_CNT, v); check("R6 run under debug", v, 103);
        dbg_halt = 1'b0;
        idle(2);
        rd(A_CNT, v); check("R11 resumes", v, 105);
    endtask

    task automatic t_collide;
        logic [31:0] v;
        wr(A_CTRL, 3);
        wr(A_CNT, 3);
        idle(2);
        rd(A_CNT, v); check("R11 load then count", v, 5);
        wr(A_CNT, 1);
        rd(A_CNT, v); check("R10 load on expiry", v, 1);
        check("R10 expiry suppressed", {16'h0, thr_irq}, 0);
        idle(4);
        wr(A_CTRL, 3);
        check("R10 ctrl write on expiry", {16'h0, thr_irq}, 0);
        rd(A_CNT, v); check("R10 wrap still taken", v, 0);
        idle(5);
        check("R4 quiet at limit", {16'h0, thr_irq}, 0);
        idle(1);
        check("R4 rearmed expiry", {16'h0, thr_irq}, 32'h8005);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_regmap;
        t_schedule;
        t_mask_live;
        t_ack;
        t_disarmed_wrap;
        t_halt;
        t_collide;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule